// File: doc/BRIEF.md
# Load-Store Data-Bus Front End

This block sits between a CPU pipeline's memory stage and a data-bus channel. It accepts one load or store operation at a time: an access size, a signedness flag, a byte address and store data. It turns the operation into a single request on a valid/ready channel. For stores it places the data in the byte lanes the address selects and sets matching byte enables. For loads the byte enables and write data stay at zero. The response returns on a second, independent valid/ready channel. Load data is shifted down from its lane and extended to 32 bits, either with sign or with zeros.

Alignment is checked before anything goes on the bus. A misaligned operation never produces a request. It is reported on the completion output with a load or store misalignment cause code. A bus response carrying the one-bit error flag is split by access direction into a load or store access-fault cause. Every operation ends in a one-cycle completion pulse.

The controller has four states. IDLE accepts an operation. ISSUE presents the request until the slave takes it. WAIT holds response-ready high until the response arrives. REPORT pulses the completion output. The transitions are:
- IDLE→ISSUE on an aligned operation.
- IDLE→REPORT on a misaligned one.
- ISSUE→WAIT on request acceptance.
- WAIT→REPORT on response acceptance.
- REPORT→IDLE unconditionally.

Top module: `ldst_bus_front`

## Requirements
- R1: The request payload carries a 32-bit byte address, a write flag (1 = write), a 2-bit size (00 byte, 01 halfword, 10 word), 32-bit write data, 4-bit byte enables and a 4-bit atomic opcode field. The atomic opcode field is always zero, and the size on the bus is never 11.
- R2: On a store, the byte enables mark exactly the lanes starting at lane addr[1:0]: one lane for a byte, two for a halfword, four for a word. The write data is the store data shifted left by 8×addr[1:0] with unmarked lanes zero. The address is the operation's address.
- R3: On a load, the write flag, byte enables and write data are all zero.
- R4: A halfword access with addr[0]=1, or a word access with addr[1:0]≠0, issues no request. The cycle after acceptance it completes with the exception flag set, cause 4 for a load or cause 6 for a store.
- R5: A response with the error flag set completes with the exception flag set, cause 5 for a load or cause 7 for a store, and data zero.
- R6: A successful load returns the addressed byte, halfword or word shifted down to bit 0. It is sign-extended when the unsigned flag is 0 and zero-extended when it is 1.
- R7: Only one transaction is outstanding. Operation-ready is high only in IDLE. The request stays valid and unchanged while request-ready is low. No new request starts before the response to the previous one.
- R8: Response-ready is high exactly while a response is awaited, and any response latency is accepted.
- R9: Completion-valid is a one-cycle pulse, one cycle after the response is accepted. A successful operation reports exception flag 0 and cause 0. A store reports data zero.
- R10: After reset, operation-ready is 1 and request-valid, response-ready and completion-valid are 0.
- R11: Size code 11 on the operation input is handled as a word access: it follows the word alignment rule and is sent with size 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered by the pipeline |
| op_ready | output | 1 | Operation accepted when high with op_valid |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| op_unsigned | input | 1 | 1 = zero-extend load data |
| op_addr | input | 32 | Byte address |
| op_wdata | input | 32 | Store data, right-aligned |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Slave accepts request |
| req_payload | output | 75 | Request payload struct (bus_req_t) |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Front end accepts response |
| rsp_rdata | input | 32 | Response read data |
| rsp_err | input | 1 | Slave access-fault flag |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Extended load data |
| done_exc | output | 1 | Operation raised an exception |
| done_cause | output | 4 | Exception cause code |

## Verification
The bound checker watches several rules on every cycle:
- the request stays stable under backpressure;
- the atomic field stays zero and the size code is never 11;
- loads carry no enables or data;
- no second request starts while one is outstanding, and response-ready rises only then;
- store strobe counts and word alignment on the bus are correct;
- misaligned operations complete the next cycle without a request;
- error responses end in an exception, and completion is a single pulse.

Only the bench scenarios can show that the right lanes, data and cause codes appear for particular addresses. The same holds for the correctness of sign and zero extension for each size and lane, and for completion at varied request and response latencies.

// File: rtl/ldst_pkg.sv
`timescale 1ns/1ps
package ldst_pkg;
    localparam int unsigned XLEN    = 32;
    localparam int unsigned STRB_W  = XLEN / 8;
    localparam int unsigned OFS_W   = $clog2(STRB_W);
    localparam int unsigned AMO_W   = 4;
    localparam int unsigned CAUSE_W = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [XLEN-1:0]   addr;
        logic              we;
        logic [1:0]        size;
        logic [XLEN-1:0]   wdata;
        logic [STRB_W-1:0] wstrb;
        logic [AMO_W-1:0]  amo;
    } bus_req_t;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE        = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_MISALIGN = 4'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT    = 4'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_MISALIGN = 4'd6;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT    = 4'd7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_REPORT
    } fe_state_e;
endpackage

// File: rtl/ldst_align_check.sv
`timescale 1ns/1ps
module ldst_align_check
    import ldst_pkg::*;
#(
    parameter int unsigned OFFSET_W = 2
) (
    input  logic [1:0]          size,
    input  logic [OFFSET_W-1:0] ofs,
    output logic                misaligned
);
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = ofs[0];
            default: misaligned = |ofs;
        endcase
    end
endmodule

// File: rtl/ldst_lane_pack.sv
`timescale 1ns/1ps
module ldst_lane_pack
    import ldst_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFFSET_W = $clog2(LANES)
) (
    input  logic                is_store,
    input  logic [1:0]          size,
    input  logic [OFFSET_W-1:0] ofs,
    input  logic [DATA_W-1:0]   data,
    output logic [DATA_W-1:0]   wdata,
    output logic [LANES-1:0]    wstrb
);
    logic [LANES-1:0]  base_strb;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        unique case (size)
            SZ_BYTE: base_strb = {{(LANES-1){1'b0}}, 1'b1};
            SZ_HALF: base_strb = {{(LANES-2){1'b0}}, 2'b11};
            default: base_strb = '1;
        endcase
        wstrb = is_store ? (base_strb << ofs) : '0;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_mask[8*i +: 8] = {8{wstrb[i]}};
    end

    assign shifted = data << {ofs, 3'b000};
    assign wdata   = shifted & lane_mask;
endmodule

// File: rtl/ldst_load_extract.sv
`timescale 1ns/1ps
module ldst_load_extract
    import ldst_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFFSET_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0]   rdata,
    input  logic [OFFSET_W-1:0] ofs,
    input  logic [1:0]          size,
    input  logic                is_unsigned,
    output logic [DATA_W-1:0]   value
);
    logic [DATA_W-1:0] aligned;
    logic              sbit;

    assign aligned = rdata >> {ofs, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                sbit  = aligned[7] & ~is_unsigned;
                value = {{(DATA_W-8){sbit}}, aligned[7:0]};
            end
            SZ_HALF: begin
                sbit  = aligned[15] & ~is_unsigned;
                value = {{(DATA_W-16){sbit}}, aligned[15:0]};
            end
            default: begin
                sbit  = 1'b0;
                value = aligned;
            end
        endcase
    end
endmodule

// File: rtl/ldst_bus_front.sv
`timescale 1ns/1ps
module ldst_bus_front
    import ldst_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    output logic                op_ready,
    input  logic                op_store,
    input  logic [1:0]          op_size,
    input  logic                op_unsigned,
    input  logic [XLEN-1:0]     op_addr,
    input  logic [XLEN-1:0]     op_wdata,
    output logic                req_valid,
    input  logic                req_ready,
    output bus_req_t            req_payload,
    input  logic                rsp_valid,
    output logic                rsp_ready,
    input  logic [XLEN-1:0]     rsp_rdata,
    input  logic                rsp_err,
    output logic                done_valid,
    output logic [XLEN-1:0]     done_rdata,
    output logic                done_exc,
    output logic [CAUSE_W-1:0]  done_cause
);
    fe_state_e state_q, state_d;

    logic              store_q;
    logic [1:0]        size_q;
    logic              uns_q;
    logic [XLEN-1:0]   addr_q;
    logic [XLEN-1:0]   data_q;
    logic [XLEN-1:0]   res_data_q;
    logic              res_exc_q;
    logic [CAUSE_W-1:0] res_cause_q;

    logic              op_fire;
    logic              rsp_fire;
    logic              op_misaligned;
    logic [1:0]        op_size_norm;
    logic [XLEN-1:0]   pk_wdata;
    logic [STRB_W-1:0] pk_wstrb;
    logic [XLEN-1:0]   ld_value;

    // Reserved size code collapses onto a word access.
    assign op_size_norm = (op_size == SZ_RSVD) ? SZ_WORD : op_size;
    assign op_fire      = op_valid && (state_q == ST_IDLE);
    assign rsp_fire     = rsp_valid && (state_q == ST_WAIT);

    ldst_align_check #(.OFFSET_W(OFS_W)) u_align (
        .size       (op_size_norm),
        .ofs        (op_addr[OFS_W-1:0]),
        .misaligned (op_misaligned)
    );

    ldst_lane_pack #(.DATA_W(XLEN)) u_pack (
        .is_store (store_q),
        .size     (size_q),
        .ofs      (addr_q[OFS_W-1:0]),
        .data     (data_q),
        .wdata    (pk_wdata),
        .wstrb    (pk_wstrb)
    );

    ldst_load_extract #(.DATA_W(XLEN)) u_extract (
        .rdata       (rsp_rdata),
        .ofs         (addr_q[OFS_W-1:0]),
        .size        (size_q),
        .is_unsigned (uns_q),
        .value       (ld_value)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (op_valid)  state_d = op_misaligned ? ST_REPORT : ST_ISSUE;
            ST_ISSUE:  if (req_ready) state_d = ST_WAIT;
            ST_WAIT:   if (rsp_valid) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Operation and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q     <= 1'b0;
            size_q      <= SZ_BYTE;
            uns_q       <= 1'b0;
            addr_q      <= '0;
            data_q      <= '0;
            res_data_q  <= '0;
            res_exc_q   <= 1'b0;
            res_cause_q <= CAUSE_NONE;
        end else begin
            if (op_fire) begin
                store_q <= op_store;
                size_q  <= op_size_norm;
                uns_q   <= op_unsigned;
                addr_q  <= op_addr;
                data_q  <= op_wdata;
                if (op_misaligned) begin
                    res_data_q  <= '0;
                    res_exc_q   <= 1'b1;
                    res_cause_q <= op_store ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN;
                end
            end
            if (rsp_fire) begin
                res_exc_q   <= rsp_err;
                res_cause_q <= !rsp_err ? CAUSE_NONE
                             : (store_q ? CAUSE_ST_FAULT : CAUSE_LD_FAULT);
                res_data_q  <= (!store_q && !rsp_err) ? ld_value : '0;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        op_ready   = 1'b0;
        req_valid  = 1'b0;
        rsp_ready  = 1'b0;
        done_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   op_ready   = 1'b1;
            ST_ISSUE:  req_valid  = 1'b1;
            ST_WAIT:   rsp_ready  = 1'b1;
            ST_REPORT: done_valid = 1'b1;
            default:   op_ready   = 1'b0;
        endcase

        req_payload.addr  = addr_q;
        req_payload.we    = store_q;
        req_payload.size  = size_q;
        req_payload.wdata = pk_wdata;
        req_payload.wstrb = pk_wstrb;
        req_payload.amo   = '0;

        done_rdata = done_valid ? res_data_q  : '0;
        done_exc   = done_valid && res_exc_q;
        done_cause = done_valid ? res_cause_q : CAUSE_NONE;
    end
endmodule

// File: rtl/ldst_bus_front_chk.sv
`timescale 1ns/1ps
module ldst_bus_front_chk
    import ldst_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic               op_ready,
    input logic [1:0]         op_size,
    input logic [OFS_W-1:0]   op_ofs,
    input logic               req_valid,
    input logic               req_ready,
    input bus_req_t           req_payload,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic               rsp_err,
    input logic               done_valid,
    input logic               done_exc
);
    logic pending;
    logic op_mis;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       pending <= 1'b0;
        else if (req_valid && req_ready)  pending <= 1'b1;
        else if (rsp_valid && rsp_ready)  pending <= 1'b0;
    end

    always_comb begin
        if (op_size == 2'b00)      op_mis = 1'b0;
        else if (op_size == 2'b01) op_mis = op_ofs[0];
        else                       op_mis = (op_ofs != '0);
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_payload));

    // R1
    amo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_payload.amo == '0 && req_payload.size != 2'b11);

    // R3
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_payload.we |-> req_payload.wstrb == '0 && req_payload.wdata == '0);

    // R2
    strb_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_payload.we |->
            $countones(req_payload.wstrb) ==
            ((req_payload.size == 2'b00) ? 1 : (req_payload.size == 2'b01) ? 2 : 4));

    // R4
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_payload.size == 2'b10 |-> req_payload.addr[1:0] == 2'b00);

    // R7
    single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !pending);

    // R8
    rsp_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> pending);

    // R4
    misalign_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && op_mis |=> done_valid && done_exc && !req_valid);

    // R5
    bus_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && rsp_err |=> done_valid && done_exc);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
endmodule

bind ldst_bus_front ldst_bus_front_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_ready    (op_ready),
    .op_size     (op_size),
    .op_ofs      (op_addr[ldst_pkg::OFS_W-1:0]),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_payload (req_payload),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_err     (rsp_err),
    .done_valid  (done_valid),
    .done_exc    (done_exc)
);

// File: tb/ldst_bus_front_test.sv
`timescale 1ns/1ps
module ldst_bus_front_test;
    import ldst_pkg::*;

    typedef struct {
        logic        exc;
        logic [3:0]  cause;
        logic [31:0] rdata;
        string       tag;
    } done_item_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        op_valid, op_ready, op_store, op_unsigned;
    logic [1:0]  op_size;
    logic [31:0] op_addr, op_wdata;
    logic        req_valid, req_ready;
    bus_req_t    req_payload;
    logic        rsp_valid, rsp_ready, rsp_err;
    logic [31:0] rsp_rdata;
    logic        done_valid, done_exc;
    logic [31:0] done_rdata;
    logic [3:0]  done_cause;

    int checks = 0;
    int failures = 0;
    int done_seen = 0;
    bit finished = 0;
    done_item_t exp_q[$];

    ldst_bus_front uut (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_ready(op_ready), .op_store(op_store),
        .op_size(op_size), .op_unsigned(op_unsigned), .op_addr(op_addr),
        .op_wdata(op_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_payload(req_payload),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err),
        .done_valid(done_valid), .done_rdata(done_rdata), .done_exc(done_exc),
        .done_cause(done_cause)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [74:0] act, input logic [74:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every completion pulse
    always @(negedge clk) begin
        if (rst_n && done_valid) begin
            done_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected completion", 75'(done_cause), 75'd0);
            end else begin
                done_item_t e;
                e = exp_q.pop_front();
                check(done_exc == e.exc, e.tag, "exception flag", 75'(done_exc), 75'(e.exc));
                check(done_cause == e.cause, e.tag, "cause", 75'(done_cause), 75'(e.cause));
                check(done_rdata == e.rdata, e.tag, "data", 75'(done_rdata), 75'(e.rdata));
            end
        end
    end

    task automatic run_op(input logic st, input logic [1:0] sz, input logic uns,
                          input logic [31:0] addr, input logic [31:0] data,
                          input logic [31:0] bus_rdata, input logic bus_err,
                          input int req_lat, input int rsp_lat, input string tag);
        int         nb;
        int         ofs;
        bit         mis;
        bus_req_t   ereq;
        done_item_t e;
        logic [63:0] m64;
        logic [31:0] sh;
        int         seen_before;

        ofs = int'(addr[1:0]);
        nb  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        mis = (sz == 2'b00) ? 1'b0 : (sz == 2'b01) ? addr[0] : (addr[1:0] != 2'b00);
        m64 = (64'd1 << (8 * nb)) - 64'd1;

        ereq.addr  = addr;
        ereq.we    = st;
        ereq.size  = (sz == 2'b11) ? 2'b10 : sz;
        ereq.wdata = st ? 32'((64'(data) & m64) << (8 * ofs)) : 32'd0;
        ereq.wstrb = st ? 4'(((5'd1 << nb) - 5'd1) << ofs) : 4'd0;
        ereq.amo   = 4'd0;

        sh = bus_rdata >> (8 * ofs);
        e.tag = tag;
        if (mis) begin
            e.exc = 1'b1; e.cause = st ? 4'd6 : 4'd4; e.rdata = 32'd0;
        end else if (bus_err) begin
            e.exc = 1'b1; e.cause = st ? 4'd7 : 4'd5; e.rdata = 32'd0;
        end else begin
            e.exc = 1'b0; e.cause = 4'd0;
            if (st)              e.rdata = 32'd0;
            else if (sz == 2'b00) e.rdata = uns ? {24'd0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
            else if (sz == 2'b01) e.rdata = uns ? {16'd0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
            else                 e.rdata = sh;
        end
        exp_q.push_back(e);
        seen_before = done_seen;

        @(negedge clk);
        check(op_ready == 1'b1, "R7", "op_ready in idle", 75'(op_ready), 75'd1);
        op_valid = 1'b1; op_store = st; op_size = sz; op_unsigned = uns;
        op_addr = addr; op_wdata = data;
        @(negedge clk);
        op_valid = 1'b0;
        check(op_ready == 1'b0, "R7", "op_ready busy", 75'(op_ready), 75'd0);

        if (mis) begin
            check(req_valid == 1'b0, "R4", "no request on misalign", 75'(req_valid), 75'd0);
        end else begin
            for (int i = 0; i < req_lat; i++) begin
                check(req_valid == 1'b1 && req_payload == ereq, "R7", "request held",
                      75'(req_payload), 75'(ereq));
                @(negedge clk);
            end
            check(req_valid == 1'b1, "R7", "request valid", 75'(req_valid), 75'd1);
            check(req_payload == ereq, st ? "R2" : "R3", "request payload (R1 fields)",
                  75'(req_payload), 75'(ereq));
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            for (int i = 0; i < rsp_lat; i++) begin
                check(rsp_ready == 1'b1 && req_valid == 1'b0 && done_valid == 1'b0,
                      "R8", "waiting for response", 75'(rsp_ready), 75'd1);
                @(negedge clk);
            end
            check(rsp_ready == 1'b1, "R8", "rsp_ready on arrival", 75'(rsp_ready), 75'd1);
            rsp_valid = 1'b1; rsp_rdata = bus_rdata; rsp_err = bus_err;
            @(negedge clk);
            rsp_valid = 1'b0; rsp_err = 1'b0; rsp_rdata = 32'd0;
            check(rsp_ready == 1'b0, "R8", "rsp_ready dropped", 75'(rsp_ready), 75'd0);
        end
        @(negedge clk);
        check(done_valid == 1'b0 && op_ready == 1'b1, "R9", "single pulse then idle",
              75'(done_valid), 75'd0);
        check(done_seen == seen_before + 1, "R9", "one completion",
              75'(done_seen - seen_before), 75'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        op_valid = 1'b0; op_store = 1'b0; op_size = 2'b00; op_unsigned = 1'b0;
        op_addr = 32'd0; op_wdata = 32'd0;
        req_ready = 1'b0; rsp_valid = 1'b0; rsp_rdata = 32'd0; rsp_err = 1'b0;
        repeat (3) @(negedge clk);
        check(op_ready == 1'b1 && req_valid == 1'b0 && rsp_ready == 1'b0 && done_valid == 1'b0,
              "R10", "reset outputs", {71'd0, op_ready, req_valid, rsp_ready, done_valid},
              75'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(op_ready == 1'b1 && req_valid == 1'b0, "R10", "idle after reset",
              75'(op_ready), 75'd1);

        // R2 stores in several lanes and sizes
        run_op(1'b1, 2'b10, 1'b0, 32'h0000_0100, 32'hDEAD_BEEF, 32'd0, 1'b0, 0, 0, "R2");
        run_op(1'b1, 2'b00, 1'b0, 32'h0000_0203, 32'h1234_56A5, 32'd0, 1'b0, 2, 1, "R2");
        run_op(1'b1, 2'b01, 1'b0, 32'h0000_0302, 32'hFFFF_C0DE, 32'd0, 1'b0, 1, 3, "R2");
        run_op(1'b1, 2'b00, 1'b0, 32'h0000_0001, 32'h0000_0077, 32'd0, 1'b0, 0, 2, "R2");
        // R6 loads with sign and zero extension
        run_op(1'b0, 2'b00, 1'b0, 32'h0000_0401, 32'd0, 32'h1234_8056, 1'b0, 0, 0, "R6");
        run_op(1'b0, 2'b00, 1'b1, 32'h0000_0401, 32'd0, 32'h1234_8056, 1'b0, 1, 1, "R6");
        run_op(1'b0, 2'b01, 1'b0, 32'h0000_0002, 32'd0, 32'h9234_0000, 1'b0, 0, 4, "R6");
        run_op(1'b0, 2'b01, 1'b1, 32'h0000_0002, 32'd0, 32'h9234_0000, 1'b0, 3, 0, "R6");
        run_op(1'b0, 2'b00, 1'b0, 32'h0000_0003, 32'd0, 32'h7F00_0000, 1'b0, 0, 0, "R6");
        run_op(1'b0, 2'b10, 1'b0, 32'h0000_0800, 32'd0, 32'hCAFE_F00D, 1'b0, 3, 4, "R6");
        // R5 bus faults by direction
        run_op(1'b0, 2'b10, 1'b0, 32'h0000_0900, 32'd0, 32'h5555_5555, 1'b1, 1, 2, "R5");
        run_op(1'b1, 2'b01, 1'b0, 32'h0000_0A00, 32'h0000_1234, 32'd0, 1'b1, 0, 1, "R5");
        // R4 misalignment trapped before issue
        run_op(1'b0, 2'b01, 1'b0, 32'h0000_0001, 32'd0, 32'd0, 1'b0, 0, 0, "R4");
        run_op(1'b1, 2'b10, 1'b0, 32'h0000_0006, 32'h1111_2222, 32'd0, 1'b0, 0, 0, "R4");
        run_op(1'b0, 2'b10, 1'b1, 32'h0000_0003, 32'd0, 32'd0, 1'b0, 0, 0, "R4");
        run_op(1'b1, 2'b01, 1'b0, 32'h0000_0103, 32'h0000_ABCD, 32'd0, 1'b0, 0, 0, "R4");
        // R11 reserved size code behaves as word
        run_op(1'b1, 2'b11, 1'b0, 32'h0000_0008, 32'h0BAD_F00D, 32'd0, 1'b0, 1, 1, "R11");
        run_op(1'b1, 2'b11, 1'b0, 32'h0000_000A, 32'h0BAD_F00D, 32'd0, 1'b0, 0, 0, "R11");
        run_op(1'b0, 2'b11, 1'b0, 32'h0000_0010, 32'd0, 32'h8765_4321, 1'b0, 0, 1, "R11");

        check(exp_q.size() == 0, "R9", "scoreboard drained", 75'(exp_q.size()), 75'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule